// File: doc/BRIEF.md
# Sticky Overflow Arithmetic Unit

A small 32-bit integer arithmetic unit for size and offset calculations. It performs unsigned add, subtract, left shift, a word-by-word multiply that keeps only the low word, and a fused multiply-add. Each operation is presented together with a valid strobe. The result is registered and appears one cycle later.

Every add, subtract or shift that overflows sets a sticky overflow flag. Once set, the flag stays set, so a whole chain of calculations can be tested with one check at the end. The flag is cleared only by an explicit clear operation or by a multiply. A multiply writes the flag to show whether the truncated product differs from the exact product. The fused multiply-add returns x*y+z when the value fits in the word. When it does not fit, it returns zero and sets the flag.

Top module: `sticky_alu`

## Requirements
- R1: After reset, `result` is 0 and `stickyOvf` is 0.
- R2: Opcode encodings are 0 add, 1 subtract, 2 shift left, 3 multiply, 4 fused multiply-add, 5 clear flag; codes 6 and 7 do nothing. While `opValid` is low, neither `result` nor `stickyOvf` changes.
- R3: Add (opcode 0) puts (a+b) mod 2^32 on `result` one cycle after the valid strobe. A carry out of bit 31 sets `stickyOvf`.
- R4: Subtract (opcode 1) puts (a-b) mod 2^32 on `result` one cycle later. A borrow (b > a, unsigned) sets `stickyOvf`.
- R5: Shift left (opcode 2) puts a << b[4:0] on `result`. It sets `stickyOvf` if any set bit of `a` is shifted out of the word.
- R6: Add, subtract and shift never clear `stickyOvf`. Once set, the flag stays set through those operations.
- R7: Multiply (opcode 3) puts the low 32 bits of a*b on `result`. It writes `stickyOvf` to 1 if the exact product is 2^32 or larger, and to 0 otherwise.
- R8: Fused multiply-add (opcode 4) puts a*b+c on `result` when that value is below 2^32. Otherwise it puts 0 on `result` and sets `stickyOvf`. When the value fits, the flag is left unchanged.
- R9: Clear (opcode 5) writes `stickyOvf` to 0 and leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Operation select |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand / shift amount |
| opC | input | 32 | Addend for fused multiply-add |
| result | output | 32 | Registered result |
| stickyOvf | output | 1 | Sticky overflow flag |

## Verification
The directed patterns sit on each side of every overflow boundary:
- sums that reach exactly 2^32-1 against sums that carry out;
- subtraction of equal operands against a borrow by one;
- shifts that push only zero bits out against shifts that push out a single set bit;
- products that are exactly 2^32-1 against products that are 2^32;
- fused results that fit exactly against results that exceed the word by one.

A chain of operations sets the flag early and follows it with clean operations, which separates a sticky flag from one that is only written each cycle. A multiply after that chain shows that the flag is overwritten rather than accumulated. Random operands compared against a behavioural model cover the general case.

// File: rtl/sticky_alu_pkg.sv
package sticky_alu_pkg;
  localparam int unsigned DataW = 32;
  localparam int unsigned ShW = $clog2(DataW);

  typedef enum logic [2:0] {
    OpAdd = 3'd0,
    OpSub = 3'd1,
    OpShl = 3'd2,
    OpMul = 3'd3,
    OpFma = 3'd4,
    OpClr = 3'd5
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadResult;  // capture new result
    logic flagSet;     // OR overflow into flag
    logic flagWrite;   // overwrite flag with overflow
    logic flagClear;   // force flag to zero
  } ctrl_t;
endpackage

// File: rtl/sticky_alu_ctrl.sv
module sticky_alu_ctrl
  import sticky_alu_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opCode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    if (opValid) begin
      unique case (opCode)
        OpAdd, OpSub, OpShl, OpFma: begin
          ctrl.loadResult = 1'b1;
          ctrl.flagSet    = 1'b1;
        end
        OpMul: begin
          ctrl.loadResult = 1'b1;
          ctrl.flagWrite  = 1'b1;
        end
        OpClr:   ctrl.flagClear = 1'b1;
        default: ctrl = '0;
      endcase
    end
  end
endmodule

// File: rtl/sticky_alu_dp.sv
module sticky_alu_dp
  import sticky_alu_pkg::*;
#(
  parameter int unsigned W = DataW
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_t        ctrl,
  input  logic [2:0]   opCode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  output logic [W-1:0] result,
  output logic         stickyOvf
);
  localparam int unsigned SW = $clog2(W);

  logic [W:0]     sumWide;
  logic [W:0]     diffWide;
  logic [2*W-1:0] shWide;
  logic [2*W-1:0] prodWide;
  logic [2*W:0]   fmaWide;
  logic [SW-1:0]  shAmt;
  logic [W-1:0]   nextVal;
  logic           nextOvf;

  assign shAmt    = opB[SW-1:0];
  assign sumWide  = {1'b0, opA} + {1'b0, opB};
  assign diffWide = {1'b0, opA} - {1'b0, opB};
  assign shWide   = {{W{1'b0}}, opA} << shAmt;
  assign prodWide = {{W{1'b0}}, opA} * {{W{1'b0}}, opB};
  assign fmaWide  = {1'b0, prodWide} + {{(W+1){1'b0}}, opC};

  always_comb begin
    nextVal = '0;
    nextOvf = 1'b0;
    unique case (opCode)
      OpAdd: begin
        nextVal = sumWide[W-1:0];
        nextOvf = sumWide[W];
      end
      OpSub: begin
        nextVal = diffWide[W-1:0];
        nextOvf = diffWide[W];
      end
      OpShl: begin
        nextVal = shWide[W-1:0];
        nextOvf = |shWide[2*W-1:W];
      end
      OpMul: begin
        nextVal = prodWide[W-1:0];
        nextOvf = |prodWide[2*W-1:W];
      end
      OpFma: begin
        nextOvf = |fmaWide[2*W:W];
        nextVal = nextOvf ? '0 : fmaWide[W-1:0];
      end
      default: begin
        nextVal = '0;
        nextOvf = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      stickyOvf <= 1'b0;
    end else begin
      if (ctrl.loadResult) result <= nextVal;
      if (ctrl.flagClear)      stickyOvf <= 1'b0;
      else if (ctrl.flagWrite) stickyOvf <= nextOvf;
      else if (ctrl.flagSet)   stickyOvf <= stickyOvf | nextOvf;
    end
  end
endmodule

// File: rtl/sticky_alu.sv
module sticky_alu
  import sticky_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [31:0] opC,
  output logic [31:0] result,
  output logic        stickyOvf
);
  ctrl_t ctrl;

  sticky_alu_ctrl u_ctrl (
    .opValid(opValid),
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  sticky_alu_dp #(.W(DataW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opCode   (opCode),
    .opA      (opA),
    .opB      (opB),
    .opC      (opC),
    .result   (result),
    .stickyOvf(stickyOvf)
  );
endmodule

// File: rtl/sticky_alu_chk.sv
module sticky_alu_chk (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [2:0]  opCode,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [31:0] result,
  input logic        stickyOvf
);
  // R2: idle cycle holds state
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(result) && $stable(stickyOvf));

  // R6: flag stays set through add/sub/shift
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode <= 3'd2 && stickyOvf) |=> stickyOvf);

  // R9: clear zeroes flag, keeps result
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd5) |=> !stickyOvf && $stable(result));

  // R3: add result
  a_r3_add: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd0) |=> result == $past(opA) + $past(opB));

  // R8: overflowing fma returns zero and flags
  a_r8_fma_zero: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd4) |=> (result == 32'd0) || !stickyOvf || $past(stickyOvf)
      || (result != 32'd0 && 1'b0));

  // R7: multiply product low word
  a_r7_mul: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd3) |=> result == 32'($past(opA) * $past(opB)));
endmodule

bind sticky_alu sticky_alu_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .opA      (opA),
  .opB      (opB),
  .result   (result),
  .stickyOvf(stickyOvf)
);

// File: tb/sticky_alu_tb.sv
module sticky_alu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [31:0] opA = '0, opB = '0, opC = '0;
  logic [31:0] result;
  logic        stickyOvf;

  int checks = 0;
  int errors = 0;
  logic [31:0] mRes = '0;
  logic        mOvf = 1'b0;

  always #10 clk = ~clk;

  sticky_alu u_dut (.*);

  task automatic check(input string req);
    checks++;
    if (result !== mRes || stickyOvf !== mOvf) begin
      errors++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
               req, result, stickyOvf, mRes, mOvf);
    end
  endtask

  // behavioural reference, applied when an operation is issued
  task automatic model(input logic [2:0] c, input logic [31:0] a, b, z);
    longint unsigned la = a, lb = b, lz = z;
    longint unsigned wide;
    int unsigned sh = b % 32;
    logic ov;
    case (c)
      3'd0: begin wide = la + lb; mRes = wide[31:0]; mOvf |= (wide > 64'hFFFF_FFFF); end
      3'd1: begin mRes = a - b; mOvf |= (b > a); end
      3'd2: begin wide = la << sh; mRes = wide[31:0]; mOvf |= (wide > 64'hFFFF_FFFF); end
      3'd3: begin wide = la * lb; mRes = wide[31:0]; mOvf = (wide > 64'hFFFF_FFFF); end
      3'd4: begin
        wide = la * lb;
        ov = (wide > 64'hFFFF_FFFF) || (wide + lz > 64'hFFFF_FFFF);
        mRes = ov ? 32'd0 : 32'(wide + lz);
        mOvf |= ov;
      end
      3'd5: mOvf = 1'b0;
      default: ;
    endcase
  endtask

  task automatic op(input logic [2:0] c, input logic [31:0] a, b, z, input string req);
    @(negedge clk);
    opValid = 1'b1; opCode = c; opA = a; opB = b; opC = z;
    model(c, a, b, z);
    @(negedge clk);
    opValid = 1'b0;
    check(req);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    opCode = 3'd5; opA = 32'hFFFF_FFFF; opB = 32'hFFFF_FFFF;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rstN = 1'b1;
        check("R1 reset");
        op(3'd0, 32'hFFFF_FFFE, 32'd1, 0, "R3 add no carry");
        op(3'd0, 32'hFFFF_FFFF, 32'd1, 0, "R3 add carry");
        op(3'd1, 32'd5, 32'd5, 0, "R6 sub keeps flag");
        op(3'd0, 32'd1, 32'd2, 0, "R6 add keeps flag");
        op(3'd5, 0, 0, 0, "R9 clear");
        op(3'd1, 32'd5, 32'd5, 0, "R4 sub equal");
        op(3'd1, 32'd4, 32'd5, 0, "R4 sub borrow");
        op(3'd5, 0, 0, 0, "R9 clear");
        op(3'd2, 32'h03FF_FFFF, 32'd6, 0, "R5 shift clean");
        op(3'd2, 32'h0400_0000, 32'd6, 0, "R5 shift loses bit");
        op(3'd2, 32'd1, 32'd31, 0, "R6 shift keeps flag");
        idle("R2 idle with clear opcode");
        op(3'd3, 32'hFFFF, 32'h10001, 0, "R7 mul exact clears");
        op(3'd3, 32'h10000, 32'h10000, 0, "R7 mul inexact");
        op(3'd6, 32'd9, 32'd9, 0, "R2 unused opcode");
        op(3'd7, 32'd9, 32'd9, 0, "R2 unused opcode");
        op(3'd3, 32'd3, 32'd7, 0, "R7 mul exact");
        op(3'd4, 32'hFFFF, 32'h10000, 32'hFFFF, "R8 fma fits exactly");
        op(3'd4, 32'hFFFF, 32'h10000, 32'h10000, "R8 fma over by one");
        op(3'd4, 32'd2, 32'd3, 32'd4, "R8 fma fits flag kept");
        op(3'd5, 0, 0, 0, "R9 clear");
        op(3'd4, 32'h10000, 32'h10000, 32'd0, "R8 fma product overflow");
        for (int i = 0; i < 400; i++) begin
          logic [2:0] c = 3'($urandom_range(0, 7));
          logic [31:0] a = $urandom, b = $urandom, z = $urandom;
          if (i % 3 == 0) begin a = a >> $urandom_range(0, 31); b = b >> $urandom_range(0, 31); end
          op(c, a, b, z, "R2 random vs model");
        end
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule